// File: doc/BRIEF.md
# DDR2 Mode Register Programming Sequencer

This block sits in a DDR2 memory controller and writes the device's mode register. A client presents one configuration request through a valid/ready handshake. The request carries the burst length, the burst order, the CAS latency, the write recovery time in nanoseconds, the clock period in picoseconds, a DLL reset flag and the active power-down exit choice. The block converts the write recovery time into a whole number of clocks, rounding up. It checks that every field can be encoded and that an external bank tracker reports all banks precharged with CKE high. It then builds the address word and drives a one-cycle mode register write on the command pins.

After the command it holds off for a programmable number of cycles, `tmrd_cycles`, before it pulses `done` and accepts the next request. A request that fails any check produces no command; a one-cycle `err` pulse is raised instead. Outside the command cycle the pins rest at NOP, with chip select high.

Top module: `ddr2_mrs_issuer`

## Requirements
- R1: The command cycle drives chip select, RAS, CAS, WE and every bank address bit low together for exactly one cycle. In every other cycle the four command pins are high (NOP) and the bank address is zero.
- R2: Address bits [2:0] carry 3'b010 for a burst length request of 4 and 3'b011 for 8. Any other requested length is rejected with `err`.
- R3: Address bit 3 copies the burst order: 0 gives sequential and 1 gives interleaved.
- R4: Address bits [6:4] carry the CAS latency as a plain binary value, from 2 (3'b010) to 5 (3'b101). A latency outside 2..5 is rejected with `err`.
- R5: Address bit 7 (test mode), bit 13 and every bit above 13 are driven 0 during a command.
- R6: Address bit 8 copies the DLL reset flag.
- R7: Address bit 12 copies the power-down exit choice: 0 gives fast exit and 1 gives slow exit.
- R8: The write recovery count is ceil(req_wr_ns*1000 / req_tck_ps). Address bits [11:9] carry that count minus one, so 2..6 clocks become codes 3'b001..3'b101. A count outside 2..6, or a zero clock period, is rejected with `err`.
- R9: A request accepted while `banks_idle` or `cke_high` is low produces no command. `err` is high in the next cycle instead.
- R10: `req_ready` is high only while no command is pending. An accepted valid request produces its command or its `err` pulse in the next cycle. After a rejection, `req_ready` stays high.
- R11: `done` is high for one cycle, exactly `tmrd_cycles` cycles after the command cycle. A value of 0 counts as 1. `req_ready` returns high in that same cycle.
- R12: While reset is asserted the pins show NOP, `req_ready` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_bl | input | 4 | Burst length as a number (4 or 8) |
| req_bt | input | 1 | Burst order, 1 = interleaved |
| req_cl | input | 3 | CAS latency in clocks |
| req_wr_ns | input | WRNS_W | Write recovery time in ns |
| req_tck_ps | input | TCK_W | Clock period in ps |
| req_dll_rst | input | 1 | Request a DLL reset |
| req_pd_slow | input | 1 | Slow power-down exit |
| tmrd_cycles | input | TMRD_W | Hold-off after the command, in cycles |
| banks_idle | input | 1 | All banks are precharged |
| cke_high | input | 1 | CKE is high |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address word |
| done | output | 1 | Hold-off complete, one cycle |
| err | output | 1 | Request rejected, one cycle |

## Verification
The bench uses the default build: 14 address bits, 2 bank bits, an 8-bit nanosecond field and a 14-bit picosecond field. It also uses the compare-chain variant of the recovery calculation, saturating at 8 clocks. With 4 hold-off bits, the bench can exercise both the zero hold-off that is treated as 1 and a long wait of 15 cycles. The 14-bit period covers clocks from 2400 ps to 8000 ps, which places exact divisions, rounded-up fractions, and counts just below 2 and just above 6 inside the tested range.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_WAIT = 2'd2
   } mrs_state_e;

   localparam int MR_FIELD_BITS = 14;
   localparam logic [2:0] BL4_CODE = 3'b010;
   localparam logic [2:0] BL8_CODE = 3'b011;
   localparam int CL_LO = 2;
   localparam int CL_HI = 5;
   localparam int WR_LO = 2;
   localparam int WR_HI = 6;
   localparam int PS_PER_NS = 1000;

   typedef struct packed {
      logic [3:0] bl;
      logic       bt;
      logic [2:0] cl;
      logic       dll_rst;
      logic       pd_slow;
   } mrs_fields_t;
endpackage

// File: rtl/mrs_wr_calc.sv
module mrs_wr_calc #(
   parameter int WRNS_W     = 8,
   parameter int TCK_W      = 14,
   parameter int WR_SAT     = 8,
   parameter bit WR_SEARCH  = 1'b1,
   localparam int CK_W      = $clog2(WR_SAT + 1)
) (
   input  logic [WRNS_W-1:0] wr_ns,
   input  logic [TCK_W-1:0]  tck_ps,
   output logic [CK_W-1:0]   wr_ck
);
   localparam int NUM_W  = WRNS_W + 10;
   localparam int PROD_W = TCK_W + CK_W;
   localparam int W      = ((NUM_W > PROD_W) ? NUM_W : PROD_W) + 1;

   logic [W-1:0] num_w;
   logic [W-1:0] tck_w;

   assign num_w = W'(wr_ns) * W'(mrs_pkg::PS_PER_NS);
   assign tck_w = W'(tck_ps);

   generate
      if (WR_SEARCH) begin : g_search
         logic [WR_SAT-1:0] below;
         for (genvar k = 0; k < WR_SAT; k++) begin : g_step
            assign below[k] = (W'(k) * tck_w) < num_w;
         end
         assign wr_ck = CK_W'($countones(below));
      end else begin : g_divide
         logic [W-1:0] quot;
         always_comb begin
            if (tck_w == '0) quot = '0;
            else             quot = (num_w + tck_w - W'(1)) / tck_w;
         end
         assign wr_ck = (quot > W'(WR_SAT)) ? CK_W'(WR_SAT) : quot[CK_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/mrs_field_encoder.sv
module mrs_field_encoder
   import mrs_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int CK_W   = 4
) (
   input  mrs_fields_t       fields,
   input  logic [CK_W-1:0]   wr_ck,
   input  logic              tck_zero,
   output logic [ADDR_W-1:0] addr_word,
   output logic              bad_field
);
   logic            bl_ok;
   logic            cl_ok;
   logic            wr_ok;
   logic [2:0]      bl_code;
   logic [CK_W-1:0] wr_m1;

   assign bl_ok   = (fields.bl == 4'd4) || (fields.bl == 4'd8);
   assign cl_ok   = (int'(fields.cl) >= CL_LO) && (int'(fields.cl) <= CL_HI);
   assign wr_ok   = (int'(wr_ck) >= WR_LO) && (int'(wr_ck) <= WR_HI);
   assign bl_code = (fields.bl == 4'd8) ? BL8_CODE : BL4_CODE;
   assign wr_m1   = wr_ck - CK_W'(1);

   assign bad_field = !bl_ok || !cl_ok || !wr_ok || tck_zero;

   always_comb begin
      addr_word       = '0;
      addr_word[2:0]  = bl_code;
      addr_word[3]    = fields.bt;
      addr_word[6:4]  = fields.cl;
      addr_word[7]    = 1'b0;
      addr_word[8]    = fields.dll_rst;
      addr_word[11:9] = wr_m1[2:0];
      addr_word[12]   = fields.pd_slow;
      addr_word[13]   = 1'b0;
   end
endmodule

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
   parameter int TMRD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [TMRD_W-1:0] limit,
   output logic              expired
);
   logic [TMRD_W-1:0] cnt_q;
   logic [TMRD_W-1:0] lim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= TMRD_W'(1);
      end else if (start) begin
         cnt_q <= TMRD_W'(1);
         lim_q <= (limit == '0) ? TMRD_W'(1) : limit;
      end else if (run && !expired) begin
         cnt_q <= cnt_q + TMRD_W'(1);
      end
   end

   assign expired = (cnt_q >= lim_q);
endmodule

// File: rtl/ddr2_mrs_issuer.sv
module ddr2_mrs_issuer
   import mrs_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int BA_W      = 2,
   parameter int WRNS_W    = 8,
   parameter int TCK_W     = 14,
   parameter int TMRD_W    = 4,
   parameter int WR_SAT    = 8,
   parameter bit WR_SEARCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_bl,
   input  logic              req_bt,
   input  logic [2:0]        req_cl,
   input  logic [WRNS_W-1:0] req_wr_ns,
   input  logic [TCK_W-1:0]  req_tck_ps,
   input  logic              req_dll_rst,
   input  logic              req_pd_slow,
   input  logic [TMRD_W-1:0] tmrd_cycles,
   input  logic              banks_idle,
   input  logic              cke_high,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BA_W-1:0]   mem_ba,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              done,
   output logic              err
);
   localparam int CK_W = $clog2(WR_SAT + 1);

   generate
      if (ADDR_W < MR_FIELD_BITS) begin : g_chk_addr
         $error("ADDR_W must cover the 14 mode register bits");
      end
      if (BA_W < 2) begin : g_chk_ba
         $error("BA_W must be at least 2");
      end
      if (TMRD_W < 1) begin : g_chk_tmrd
         $error("TMRD_W must be at least 1");
      end
      if (WR_SAT <= WR_HI) begin : g_chk_sat
         $error("WR_SAT must exceed the largest legal recovery count");
      end
   endgenerate

   mrs_state_e        state_q;
   logic              cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;
   logic              err_q;

   mrs_fields_t       fields;
   logic [CK_W-1:0]   wr_ck;
   logic [ADDR_W-1:0] addr_word;
   logic              bad_field;
   logic              precond_ok;
   logic              accept;
   logic              issue;
   logic              timer_expired;

   assign fields = '{bl: req_bl, bt: req_bt, cl: req_cl,
                     dll_rst: req_dll_rst, pd_slow: req_pd_slow};

   mrs_wr_calc #(
      .WRNS_W    (WRNS_W),
      .TCK_W     (TCK_W),
      .WR_SAT    (WR_SAT),
      .WR_SEARCH (WR_SEARCH)
   ) u_wr_calc (
      .wr_ns  (req_wr_ns),
      .tck_ps (req_tck_ps),
      .wr_ck  (wr_ck)
   );

   mrs_field_encoder #(
      .ADDR_W (ADDR_W),
      .CK_W   (CK_W)
   ) u_encoder (
      .fields    (fields),
      .wr_ck     (wr_ck),
      .tck_zero  (req_tck_ps == '0),
      .addr_word (addr_word),
      .bad_field (bad_field)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign precond_ok = banks_idle && cke_high;
   assign issue      = accept && precond_ok && !bad_field;

   mrs_wait_timer #(
      .TMRD_W (TMRD_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (issue),
      .run     (state_q != ST_IDLE),
      .limit   (tmrd_cycles),
      .expired (timer_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= 1'b0;
         addr_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         cmd_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (issue) begin
                  cmd_q   <= 1'b1;
                  addr_q  <= addr_word;
                  state_q <= ST_CMD;
               end else if (accept) begin
                  err_q <= 1'b1;
               end
            end
            ST_CMD, ST_WAIT: begin
               if (timer_expired) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_cs_n  = !cmd_q;
   assign mem_ras_n = !cmd_q;
   assign mem_cas_n = !cmd_q;
   assign mem_we_n  = !cmd_q;
   assign mem_ba    = '0;
   assign mem_addr  = cmd_q ? addr_q : '0;
   assign done      = done_q;
   assign err       = err_q;
endmodule

// File: rtl/ddr2_mrs_issuer_chk.sv
module ddr2_mrs_issuer_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              banks_idle,
   input logic              cke_high,
   input logic              mem_cs_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic              err
);
   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |=> mem_cs_n);  // R1
   AST_BL_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> (mem_addr[2:0] == 3'b010 || mem_addr[2:0] == 3'b011));  // R2
   AST_CL_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> (mem_addr[6:4] >= 3'd2 && mem_addr[6:4] <= 3'd5));  // R4
   AST_WR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> (mem_addr[11:9] >= 3'd1 && mem_addr[11:9] <= 3'd5));  // R8
   AST_CMD_NEEDS_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> $past(req_valid && req_ready && banks_idle && cke_high));  // R9
   AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(banks_idle && cke_high)) |=> (err && mem_cs_n));  // R9
   AST_CMD_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);  // R10
   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err, !mem_cs_n}));  // R11
endmodule

bind ddr2_mrs_issuer ddr2_mrs_issuer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .banks_idle (banks_idle),
   .cke_high   (cke_high),
   .mem_cs_n   (mem_cs_n),
   .mem_addr   (mem_addr),
   .done       (done),
   .err        (err)
);

// File: tb/ddr2_mrs_issuer_tb.sv
module ddr2_mrs_issuer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_bl = 4'd4;
   logic        req_bt = 1'b0;
   logic [2:0]  req_cl = 3'd3;
   logic [7:0]  req_wr_ns = 8'd15;
   logic [13:0] req_tck_ps = 14'd3750;
   logic        req_dll_rst = 1'b0;
   logic        req_pd_slow = 1'b0;
   logic [3:0]  tmrd_cycles = 4'd2;
   logic        banks_idle = 1'b1;
   logic        cke_high = 1'b1;
   logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
   logic [1:0]  mem_ba;
   logic [13:0] mem_addr;
   logic        done, err;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // reference model state
   bit     m_busy = 0;
   int     m_cyc = 0;
   int     m_lim = 1;
   bit     e_cmd = 0;
   bit     e_done = 0;
   bit     e_err = 0;
   int     e_bl, e_bt, e_cl, e_dll, e_pd, e_wr;
   string  e_err_tag = "R9";

   always #5 clk = ~clk;

   ddr2_mrs_issuer u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bl(req_bl), .req_bt(req_bt), .req_cl(req_cl), .req_wr_ns(req_wr_ns),
      .req_tck_ps(req_tck_ps), .req_dll_rst(req_dll_rst), .req_pd_slow(req_pd_slow),
      .tmrd_cycles(tmrd_cycles), .banks_idle(banks_idle), .cke_high(cke_high),
      .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
      .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   // behavioural reference, updated at each rising edge from sampled inputs
   always @(posedge clk) begin
      int num, wr, c;
      bit ok;
      e_cmd = 0; e_done = 0; e_err = 0;
      if (!rst_n) begin
         m_busy = 0;
      end else if (m_busy) begin
         m_cyc++;
         if (m_cyc >= m_lim) begin
            e_done = 1;
            m_busy = 0;
         end
      end else if (req_valid) begin
         ok = 1;
         num = int'(req_wr_ns) * 1000;
         wr = 0;
         if (req_tck_ps == 0) begin
            ok = 0; e_err_tag = "R8";
         end else begin
            for (c = 0; c < 12 && c * int'(req_tck_ps) < num; c++) wr = c + 1;
            if (wr < 2 || wr > 6) begin ok = 0; e_err_tag = "R8"; end
         end
         if (req_cl < 2 || req_cl > 5) begin ok = 0; e_err_tag = "R4"; end
         if (req_bl != 4 && req_bl != 8) begin ok = 0; e_err_tag = "R2"; end
         if (!banks_idle || !cke_high) begin ok = 0; e_err_tag = "R9"; end
         if (ok) begin
            e_cmd = 1; m_busy = 1; m_cyc = 0;
            m_lim = (tmrd_cycles == 0) ? 1 : int'(tmrd_cycles);
            e_bl = (req_bl == 8) ? 3 : 2;
            e_bt = req_bt; e_cl = req_cl; e_dll = req_dll_rst;
            e_pd = req_pd_slow; e_wr = wr - 1;
         end else begin
            e_err = 1;
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      cycles++;
      if (!rst_n) begin
         chk(mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n, "R12 nop", mem_cs_n, 1);
         chk(req_ready && !done && !err, "R12 flags", {req_ready, done, err}, 3'b100);
      end else begin
         chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == (e_cmd ? 4'b0000 : 4'b1111),
             "R1 pins", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, e_cmd ? 0 : 15);
         chk(mem_ba == 2'b00, "R1 bank", mem_ba, 0);
         chk(req_ready == !m_busy, "R10 ready", req_ready, !m_busy);
         chk(done == e_done, "R11 done", done, e_done);
         chk(err == e_err, e_err ? e_err_tag : "R10 err", err, e_err);
         if (e_cmd) begin
            chk(mem_addr[2:0] == 3'(e_bl), "R2 burst len", mem_addr[2:0], e_bl);
            chk(mem_addr[3] == e_bt[0], "R3 burst type", mem_addr[3], e_bt);
            chk(mem_addr[6:4] == 3'(e_cl), "R4 cas lat", mem_addr[6:4], e_cl);
            chk(mem_addr[7] == 1'b0 && mem_addr[13] == 1'b0, "R5 reserved",
                {mem_addr[13], mem_addr[7]}, 0);
            chk(mem_addr[8] == e_dll[0], "R6 dll", mem_addr[8], e_dll);
            chk(mem_addr[12] == e_pd[0], "R7 pd exit", mem_addr[12], e_pd);
            chk(mem_addr[11:9] == 3'(e_wr), "R8 wr code", mem_addr[11:9], e_wr);
         end
      end
   end

   task automatic send(input int bl, input int bt, input int cl, input int wrns,
                       input int tck, input int dll, input int pd, input int tmrd,
                       input bit idle, input bit cke);
      req_bl = 4'(bl); req_bt = bt[0]; req_cl = 3'(cl); req_wr_ns = 8'(wrns);
      req_tck_ps = 14'(tck); req_dll_rst = dll[0]; req_pd_slow = pd[0];
      tmrd_cycles = 4'(tmrd); banks_idle = idle; cke_high = cke;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      banks_idle = 1'b1; cke_high = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // legal requests, several encodings
      send(4, 0, 3, 15, 3750, 0, 0, 2, 1, 1);   // exact 4 clocks -> R8 code 3
      send(8, 1, 5, 15, 2500, 1, 1, 3, 1, 1);   // back-to-back, 6 clocks
      repeat (6) @(negedge clk);
      send(4, 1, 2, 15, 5000, 1, 0, 1, 1, 1);   // 3 clocks
      send(8, 0, 4, 15, 7500, 0, 1, 0, 1, 1);   // 2 clocks, R11 tmrd 0 as 1
      send(4, 0, 3, 15, 8000, 0, 0, 15, 1, 1);  // 1.875 rounds to 2, long wait
      send(8, 1, 3, 5, 3000, 1, 1, 4, 1, 1);    // 1.67 rounds to 2
      send(4, 0, 5, 15, 3000, 0, 0, 2, 1, 1);   // 5 clocks
      // rejections
      send(8, 0, 3, 15, 2400, 0, 0, 2, 1, 1);   // R8 6.25 -> 7
      send(4, 0, 3, 5, 7500, 0, 0, 2, 1, 1);    // R8 count 1
      send(4, 0, 3, 15, 0, 0, 0, 2, 1, 1);      // R8 zero period
      send(5, 0, 3, 15, 3750, 0, 0, 2, 1, 1);   // R2 illegal length
      send(4, 0, 6, 15, 3750, 0, 0, 2, 1, 1);   // R4 too high
      send(4, 0, 1, 15, 3750, 0, 0, 2, 1, 1);   // R4 too low
      send(4, 0, 3, 15, 3750, 0, 0, 2, 0, 1);   // R9 bank open
      send(4, 0, 3, 15, 3750, 0, 0, 2, 1, 0);   // R9 cke low
      send(8, 1, 4, 15, 3750, 1, 1, 2, 1, 1);   // recovery after rejections
      repeat (20) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      while (cycles < 20000) @(negedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule